// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches a single asynchronous interrupt pin and raises a sticky interrupt flag when the pin shows a qualifying event. Software controls the block through one control/status byte. The byte selects the active polarity and the detection mode, gates the interrupt request, acknowledges the flag through a write-only bit, and returns the flag as a read-only bit. The polarity is either falling edge with low level, or rising edge with high level. The detection mode is either edge only, or edge plus asserted level.

The pin passes through a synchronizer chain. The detector compares consecutive synchronized samples to find edges. In level mode, an asserted sample also counts as an event. The flag logic settles a set and a clear that arrive in the same cycle. When the enable bit is set, the flag drives a registered request output toward the interrupt controller. Changing the polarity or the mode re-primes the edge detector, so the change itself cannot fire an event.

Top module: `irq_pin_detector`

## Requirements
- R1: After reset the control/status byte reads 0x00 and the request output is 0. The default polarity is falling edge with low level.
- R2: The mode bit is bit 0. With mode bit = 0, a falling pin edge (polarity bit 4 = 0) sets the flag, which is read at bit 3, three clock edges after the pin changes. A pin held low afterwards does not set the flag again after an acknowledge, and a rising edge sets nothing.
- R3: With polarity bit 4 = 1, a rising edge sets the flag and a falling edge does not.
- R4: With mode bit = 1, an asserted pin level sets the flag. An acknowledge has no effect while the synchronized pin remains asserted. Once the pin is deasserted, an acknowledge clears the flag.
- R5: Writing 1 to bit 2 clears the flag. Writing 0 to bit 2 leaves the flag unchanged. Bit 2 always reads 0.
- R6: The enable bit is bit 1. With enable = 0, the request output stays 0 while the flag is set. With enable = 1, the request output rises one clock after the flag and enable are both 1, and falls one clock after the flag clears.
- R7: When a qualifying event and an acknowledge occur in the same cycle, the flag stays set.
- R8: A write that changes the polarity or the mode raises no event, for example when the pin rests at the newly asserted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| wr_en_i | input | 1 | Write strobe for the control/status byte |
| wdata_i | input | REG_W | Write data (bit0 mode, bit1 enable, bit2 acknowledge, bit4 polarity) |
| rdata_o | output | REG_W | Read data (bit0 mode, bit1 enable, bit2 zero, bit3 flag, bit4 polarity) |
| irq_req_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an acknowledge that lands in exactly the cycle when the detector fires. That cycle exists only after the pin edge has crossed both synchronizer stages. The bench first sets the flag with an earlier edge and returns the pin to idle. It then drives a new falling edge and issues the acknowledge write on the second clock after the change, which is exactly when the event and the clear meet. Re-priming is reached by switching the polarity while the pin rests at what becomes the asserted level.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
   localparam int unsigned BIT_MODE = 0;
   localparam int unsigned BIT_IEN  = 1;
   localparam int unsigned BIT_ACK  = 2;
   localparam int unsigned BIT_FLAG = 3;
   localparam int unsigned BIT_POL  = 4;
   localparam int unsigned MIN_W    = BIT_POL + 1;

   typedef struct packed {
      logic pol;   // 1: rising edge / high level
      logic ien;   // request enable
      logic lvl;   // 1: edge and level detection
   } irq_ctl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int unsigned STAGES   = 2,
   parameter bit          IDLE_LVL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{IDLE_LVL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic smp_i,
   input  logic pol_i,
   input  logic lvl_i,
   input  logic chg_i,
   input  logic pol_nxt_i,
   output logic act_o,
   output logic evt_o
);
   logic prev_act_q;

   assign act_o = ~(smp_i ^ pol_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    prev_act_q <= 1'b0;
      else if (chg_i) prev_act_q <= ~(smp_i ^ pol_nxt_i);
      else            prev_act_q <= act_o;
   end

   always_comb begin
      if (chg_i)      evt_o = 1'b0;
      else if (lvl_i) evt_o = act_o;
      else            evt_o = act_o & ~prev_act_q;
   end

   // R2
   single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_i && evt_o) |=> !evt_o);
endmodule

// File: rtl/irq_pin_flag.sv
module irq_pin_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic ack_i,
   input  logic lvl_i,
   input  logic act_i,
   input  logic ien_i,
   output logic flag_o,
   output logic req_o
);
   logic clr;

   assign clr = ack_i & ~(lvl_i & act_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_o <= 1'b0;
         req_o  <= 1'b0;
      end else begin
         flag_o <= evt_i | (flag_o & ~clr);
         req_o  <= flag_o & ien_i;
      end
   end

   // R7
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i |=> flag_o);
   // R4
   level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i && act_i && flag_o) |=> flag_o);
   // R6
   req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ien_i |=> !req_o);
endmodule

// File: rtl/irq_pin_detector.sv
module irq_pin_detector
   import irq_pin_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8,
   parameter bit          IDLE_LVL    = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_i,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] rdata_o,
   output logic             irq_req_o
);
   if (REG_W < MIN_W) begin : g_bad_width
      $error("irq_pin_detector: REG_W too small for the control byte");
   end

   irq_ctl_t ctl_q;
   logic     smp, act, evt, flag, ack, chg;
   logic     unused_wdata;

   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (wr_en_i) begin
         ctl_q.pol <= wdata_i[BIT_POL];
         ctl_q.ien <= wdata_i[BIT_IEN];
         ctl_q.lvl <= wdata_i[BIT_MODE];
      end
   end

   assign ack = wr_en_i & wdata_i[BIT_ACK];
   assign chg = wr_en_i & ((wdata_i[BIT_POL] != ctl_q.pol) |
                           (wdata_i[BIT_MODE] != ctl_q.lvl));

   irq_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (smp)
   );

   irq_pin_detect u_detect (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp),
      .pol_i    (ctl_q.pol),
      .lvl_i    (ctl_q.lvl),
      .chg_i    (chg),
      .pol_nxt_i(wdata_i[BIT_POL]),
      .act_o    (act),
      .evt_o    (evt)
   );

   irq_pin_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt),
      .ack_i (ack),
      .lvl_i (ctl_q.lvl),
      .act_i (act),
      .ien_i (ctl_q.ien),
      .flag_o(flag),
      .req_o (irq_req_o)
   );

   always_comb begin
      rdata_o           = '0;
      rdata_o[BIT_MODE] = ctl_q.lvl;
      rdata_o[BIT_IEN]  = ctl_q.ien;
      rdata_o[BIT_FLAG] = flag;
      rdata_o[BIT_POL]  = ctl_q.pol;
   end

   // R5
   ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack && !evt && !(ctl_q.lvl && act)) |=> !rdata_o[BIT_FLAG]);
   // R8
   reprime_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chg && $stable(smp)) |=> (ctl_q.lvl || !evt || !$stable(smp)));
endmodule

// File: tb/test_irq_pin_detector.sv
module test_irq_pin_detector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       req;
   int         total = 0;
   int         bad = 0;
   bit         finished = 0;

   always #10 clk = ~clk;

   irq_pin_detector i_irq_pin_detector (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en),
      .wdata_i(wdata), .rdata_o(rdata), .irq_req_o(req)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", rq, act, exp);
      end
   endtask

   // write one byte: bit4 pol, bit2 ack, bit1 enable, bit0 mode
   task automatic wr(input bit pol, input bit en, input bit mode, input bit ack);
      wr_en = 1'b1;
      wdata = {3'b000, pol, 1'b0, ack, en, mode};
      tick(1);
      wr_en = 1'b0;
      wdata = '0;
   endtask

   task automatic t_reset;
      check("R1 byte", rdata, 8'h00);
      check("R1 req", req, 0);
   endtask

   task automatic t_fall;
      pin = 1'b0; tick(3);
      check("R2 fall sets", rdata[3], 1);
      wr(0, 0, 0, 1);
      check("R2 ack clears", rdata[3], 0);
      tick(5);
      check("R2 held low no reset", rdata[3], 0);
      pin = 1'b1; tick(4);
      check("R2 rise ignored", rdata[3], 0);
   endtask

   task automatic t_ack;
      pin = 1'b0; tick(3);
      check("R5 setup", rdata[3], 1);
      wr(0, 0, 0, 0);
      check("R5 zero no effect", rdata[3], 1);
      check("R5 ack reads 0", rdata[2], 0);
      wr(0, 0, 0, 1);
      check("R5 ack clears", rdata[3], 0);
      check("R5 ack reads 0 after", rdata[2], 0);
      pin = 1'b1; tick(4);
   endtask

   task automatic t_rise;
      wr(1, 0, 0, 0);
      tick(4);
      check("R8 pol change no event", rdata[3], 0);
      check("R3 pol bit", rdata[4], 1);
      pin = 1'b0; tick(4);
      check("R3 fall ignored", rdata[3], 0);
      pin = 1'b1; tick(3);
      check("R3 rise sets", rdata[3], 1);
      wr(1, 0, 0, 1);
      wr(0, 0, 0, 0);
      tick(3);
      check("R8 back to falling", rdata[3], 0);
   endtask

   task automatic t_enable;
      pin = 1'b0; tick(3);
      tick(1);
      check("R6 disabled no req", req, 0);
      wr(0, 1, 0, 0);
      check("R6 req lags enable", req, 0);
      tick(1);
      check("R6 req asserted", req, 1);
      wr(0, 1, 0, 1);
      check("R6 req lags clear", req, 1);
      tick(1);
      check("R6 req dropped", req, 0);
      pin = 1'b1; tick(4);
      wr(0, 0, 0, 0);
   endtask

   task automatic t_level;
      wr(0, 0, 1, 0);
      tick(3);
      check("R4 idle no flag", rdata[3], 0);
      pin = 1'b0; tick(3);
      check("R4 level sets", rdata[3], 1);
      wr(0, 0, 1, 1);
      check("R4 ack blocked", rdata[3], 1);
      tick(2);
      check("R4 still set", rdata[3], 1);
      pin = 1'b1; tick(3);
      check("R4 holds after release", rdata[3], 1);
      wr(0, 0, 1, 1);
      check("R4 ack clears", rdata[3], 0);
      tick(3);
      check("R4 stays clear", rdata[3], 0);
      wr(0, 0, 0, 0);
   endtask

   task automatic t_collide;
      pin = 1'b0; tick(3);
      pin = 1'b1; tick(4);
      check("R7 setup", rdata[3], 1);
      pin = 1'b0; tick(2);
      wr(0, 0, 0, 1);
      check("R7 set beats ack", rdata[3], 1);
      wr(0, 0, 0, 1);
      check("R7 later ack clears", rdata[3], 0);
      pin = 1'b1; tick(4);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(3);
      t_reset();
      t_fall();
      t_ack();
      t_rise();
      t_enable();
      t_level();
      t_collide();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule